// File: doc/BRIEF.md
# Set-Associative Cache Miss Classifier

This block models the tag side of a small three-way set-associative cache with least-recently-used replacement. It holds no data. It takes one byte address per cycle and reports whether that address would hit. It also sorts every miss by cause. A miss is compulsory when its line has never been referenced since reset. It is a conflict miss when a fully-associative LRU cache of the same total size would have held the line. Every other miss is a capacity miss.

Three structures sit beside each other. The set-associative tag array keeps per-set age counters. A fully-associative shadow directory has one entry for each line of the real cache. A bounded first-touch table records the line addresses seen so far. All three are looked up in the same cycle as the access, and all three update at the following clock edge. When the first-touch table has no free slot left and a new line arrives, a sticky overflow flag rises, so that misclassifications after that point are never hidden.

Top module: `cmc_classifier`

## Requirements
- R1: A line is 16 bytes (two 8-byte words). Address bits [3:0] are the line offset, bits [6:4] select one of 8 sets, and the remaining upper bits form the tag. Two addresses that differ only in bits [3:0] refer to the same line.
- R2: When `addr_vld` is high at a rising clock edge, `res_vld` is high for exactly the following cycle and carries the result for that access. With no access, `res_vld` stays low.
- R3: A hit reports `res_hit`=1 and `res_kind`=00. A miss reports `res_hit`=0 and a nonzero `res_kind`.
- R4: A miss on a line not referenced since reset reports `res_kind`=01 (compulsory).
- R5: Each set holds 3 lines. Accessing a line makes it most recently used. A miss into a full set evicts that set's least recently used line.
- R6: A miss on a line referenced before, whose line is present in a 24-line fully-associative LRU directory updated by the same access stream, reports `res_kind`=10 (conflict).
- R7: A miss on a line referenced before, whose line is absent from that 24-line directory, reports `res_kind`=11 (capacity).
- R8: A synchronous reset invalidates every line in the cache and the directory, empties the first-touch table, and clears `res_vld` and `track_ovf`.
- R9: The first-touch table holds `TRACK_DEPTH` (default 64) lines. An access to a new line while the table is full sets `track_ovf`, which stays high until reset. That access is reported as compulsory, and its line is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_vld | input | 1 | Access request this cycle |
| addr | input | ADDR_W (16) | Byte address of the access |
| res_vld | output | 1 | Result valid, one cycle after the access |
| res_hit | output | 1 | Access hit in the set-associative cache |
| res_kind | output | 2 | 00 hit, 01 compulsory, 10 conflict, 11 capacity |
| track_ovf | output | 1 | Sticky: the first-touch table ran out of room |

## Verification
The hardest results to reach from the ports are the capacity miss and the table overflow. A capacity miss needs a line to age out of all 24 shadow entries while it is also gone from its set. The stimulus gets there by sweeping 30 distinct lines spread over every set and then returning to the first one. Overflow needs more than 64 distinct lines after a reset, so the bench resets mid-run and streams 66 new lines. The bench then checks that the flag stays high on later accesses. Conflict misses come from four lines mapped to one set, revisited while the shadow directory still holds them.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
   typedef enum logic [1:0] {
      MT_NONE       = 2'b00,
      MT_COMPULSORY = 2'b01,
      MT_CONFLICT   = 2'b10,
      MT_CAPACITY   = 2'b11
   } miss_kind_e;
endpackage

// File: rtl/cmc_lru_bank.sv
// Fully-associative group of tag entries with exact LRU order kept as
// distinct ages (0 = most recent). Used per set and for the shadow directory.
module cmc_lru_bank #(
   parameter int ENTRIES = 3,
   parameter int TAG_W   = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             upd,
   input  logic [TAG_W-1:0] tag_in,
   output logic             hit
);
   localparam int AGE_W = $clog2(ENTRIES);
   localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

   if (ENTRIES < 2) begin : g_chk_entries
      $error("cmc_lru_bank: ENTRIES must be at least 2");
   end

   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [AGE_W-1:0]   age_q [ENTRIES];
   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] match;
   logic [ENTRIES-1:0] mru_vec;
   logic [AGE_W-1:0]   ref_age;

   always_comb begin
      ref_age = OLDEST;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) ref_age = age_q[i];
      end
   end

   assign hit = |match;

   // Invalid entries always hold the oldest ages, so they fill first.
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      assign match[i]   = valid_q[i] && (tag_q[i] == tag_in);
      assign mru_vec[i] = (age_q[i] == '0);

      always_ff @(posedge clk) begin
         if (rst) begin
            valid_q[i] <= 1'b0;
            tag_q[i]   <= '0;
            age_q[i]   <= AGE_W'(i);
         end else if (upd) begin
            if (match[i] || (!hit && age_q[i] == OLDEST)) begin
               valid_q[i] <= 1'b1;
               tag_q[i]   <= tag_in;
               age_q[i]   <= '0;
            end else if (age_q[i] < ref_age) begin
               age_q[i]   <= age_q[i] + 1'b1;
            end
         end
      end
   end

   // R5: a tag is never held twice
   a_r5_single_match: assert property (@(posedge clk) disable iff (rst)
      $onehot0(match));
   // R5: the ages stay a permutation, exactly one entry is most recent
   a_r5_single_mru: assert property (@(posedge clk) disable iff (rst)
      $onehot(mru_vec));
   // R5: an updated line is most recent afterwards
   a_r5_hit_after_upd: assert property (@(posedge clk) disable iff (rst)
      upd |=> $stable(tag_in) |-> hit);
endmodule

// File: rtl/cmc_first_touch.sv
// Bounded table of line addresses referenced since reset.
module cmc_first_touch #(
   parameter int DEPTH  = 64,
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd,
   input  logic [LINE_W-1:0] line_in,
   output logic              seen,
   output logic              full
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1) begin : g_chk_depth
      $error("cmc_first_touch: DEPTH must be positive");
   end

   logic [LINE_W-1:0] line_q [DEPTH];
   logic [CNT_W-1:0]  count_q;
   logic [DEPTH-1:0]  hit_vec;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign hit_vec[i] = (CNT_W'(i) < count_q) && (line_q[i] == line_in);
   end

   assign seen = |hit_vec;
   assign full = (count_q == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
      end else if (upd && !seen && !full) begin
         line_q[PTR_W'(count_q)] <= line_in;
         count_q                 <= count_q + 1'b1;
      end
   end

   // R9: occupancy never passes the table size
   a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
      count_q <= CNT_W'(DEPTH));
   // R9: a recorded line is recognised on the next cycle
   a_r9_recorded: assert property (@(posedge clk) disable iff (rst)
      (upd && !full) |=> $stable(line_in) |-> seen);
endmodule

// File: rtl/cmc_classifier.sv
module cmc_classifier #(
   parameter int ADDR_W      = 16,
   parameter int WORD_BYTES  = 8,
   parameter int LINE_WORDS  = 2,
   parameter int WAYS        = 3,
   parameter int SETS        = 8,
   parameter int TRACK_DEPTH = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              addr_vld,
   input  logic [ADDR_W-1:0] addr,
   output logic              res_vld,
   output logic              res_hit,
   output logic [1:0]        res_kind,
   output logic              track_ovf
);
   import cmc_pkg::*;

   localparam int OFFSET_W     = $clog2(WORD_BYTES * LINE_WORDS);
   localparam int IDX_W        = $clog2(SETS);
   localparam int LINE_W       = ADDR_W - OFFSET_W;
   localparam int TAG_W        = LINE_W - IDX_W;
   localparam int SHADOW_LINES = SETS * WAYS;

   if ((1 << IDX_W) != SETS) begin : g_chk_sets
      $error("cmc_classifier: SETS must be a power of two");
   end
   if (TAG_W < 1) begin : g_chk_addr
      $error("cmc_classifier: ADDR_W too narrow for offset and index");
   end

   logic [LINE_W-1:0] line;
   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  tag;
   logic [SETS-1:0]   set_hit;
   logic              cache_hit;
   logic              shadow_hit;
   logic              line_seen;
   logic              trk_full;
   miss_kind_e        kind;

   assign line = addr[ADDR_W-1:OFFSET_W];
   assign idx  = line[IDX_W-1:0];
   assign tag  = line[LINE_W-1:IDX_W];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      cmc_lru_bank #(.ENTRIES(WAYS), .TAG_W(TAG_W)) u_set (
         .clk    (clk),
         .rst    (rst),
         .upd    (addr_vld && (idx == IDX_W'(s))),
         .tag_in (tag),
         .hit    (set_hit[s])
      );
   end

   assign cache_hit = set_hit[idx];

   cmc_lru_bank #(.ENTRIES(SHADOW_LINES), .TAG_W(LINE_W)) u_shadow (
      .clk    (clk),
      .rst    (rst),
      .upd    (addr_vld),
      .tag_in (line),
      .hit    (shadow_hit)
   );

   cmc_first_touch #(.DEPTH(TRACK_DEPTH), .LINE_W(LINE_W)) u_touch (
      .clk     (clk),
      .rst     (rst),
      .upd     (addr_vld),
      .line_in (line),
      .seen    (line_seen),
      .full    (trk_full)
   );

   always_comb begin
      if (cache_hit)       kind = MT_NONE;
      else if (!line_seen) kind = MT_COMPULSORY;
      else if (shadow_hit) kind = MT_CONFLICT;
      else                 kind = MT_CAPACITY;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_vld   <= 1'b0;
         res_hit   <= 1'b0;
         res_kind  <= MT_NONE;
         track_ovf <= 1'b0;
      end else begin
         res_vld <= addr_vld;
         if (addr_vld) begin
            res_hit  <= cache_hit;
            res_kind <= kind;
            if (!line_seen && trk_full) track_ovf <= 1'b1;
         end
      end
   end

   // R4: a line never seen cannot be held by either cache
   a_r4_new_misses: assert property (@(posedge clk) disable iff (rst)
      (addr_vld && !line_seen && !trk_full) |-> (!cache_hit && !shadow_hit));
   // R2: every access yields a result next cycle
   a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
      addr_vld |=> res_vld);
   // R2: no result without an access
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !addr_vld |=> !res_vld);
   // R9: overflow flag is sticky
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      track_ovf |=> track_ovf);
endmodule

// File: tb/cmc_classifier_bench.sv
module cmc_classifier_bench;
   localparam int SETS  = 8;
   localparam int WAYS  = 3;
   localparam int FA_N  = 24;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        addr_vld = 1'b0;
   logic [15:0] addr = '0;
   logic        res_vld, res_hit, track_ovf;
   logic [1:0]  res_kind;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int set_q [SETS][$];
   int fa_q [$];
   int seen_q [$];
   bit ovf_m;

   always #5 clk = ~clk;

   cmc_classifier u_cmc_classifier (
      .clk(clk), .rst(rst), .addr_vld(addr_vld), .addr(addr),
      .res_vld(res_vld), .res_hit(res_hit), .res_kind(res_kind),
      .track_ovf(track_ovf)
   );

   function automatic int find_in(ref int q[$], input int v);
      for (int i = 0; i < q.size(); i++) if (q[i] == v) return i;
      return -1;
   endfunction

   function automatic void model_reset();
      for (int s = 0; s < SETS; s++) set_q[s].delete();
      fa_q.delete();
      seen_q.delete();
      ovf_m = 1'b0;
   endfunction

   // Behavioural reference: queues ordered most recent first.
   function automatic void model(input int a, output bit h, output int k);
      int ln, s, p, fp, sp;
      bit fh;
      ln = a >> 4;
      s  = ln % SETS;
      p  = find_in(set_q[s], ln);
      h  = (p >= 0);
      if (h) set_q[s].delete(p);
      else if (set_q[s].size() == WAYS) void'(set_q[s].pop_back());
      set_q[s].push_front(ln);
      fp = find_in(fa_q, ln);
      fh = (fp >= 0);
      if (fh) fa_q.delete(fp);
      else if (fa_q.size() == FA_N) void'(fa_q.pop_back());
      fa_q.push_front(ln);
      sp = find_in(seen_q, ln);
      if (sp < 0) begin
         if (seen_q.size() < DEPTH) seen_q.push_back(ln);
         else ovf_m = 1'b1;
      end
      k = h ? 0 : ((sp < 0) ? 1 : (fh ? 2 : 3));
   endfunction

   task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: {vld,hit,kind,ovf} actual %b expected %b", req, act, exp);
      end
   endtask

   // Drive at a falling edge, sample at the next falling edge.
   task automatic access(input int a, input string req);
      bit h;
      int k;
      string r;
      model(a, h, k);
      addr_vld = 1'b1;
      addr     = 16'(a);
      @(negedge clk);
      if (req != "") r = req;
      else if (k == 0) r = "R3";
      else if (k == 1) r = "R4";
      else if (k == 2) r = "R6";
      else r = "R7";
      check(r, {res_vld, res_hit, res_kind, track_ovf}, {1'b1, h, 2'(k), ovf_m});
   endtask

   task automatic idle(input string req);
      addr_vld = 1'b0;
      @(negedge clk);
      check(req, {res_vld, 3'b000, track_ovf}, {1'b0, 3'b000, ovf_m});
   endtask

   task automatic do_reset();
      addr_vld = 1'b0;
      rst = 1'b1;
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R8", {res_vld, 3'b000, track_ovf}, 5'b00000);
   endtask

   int stream [15] = '{38, 172, 144, 85, 424, 111, 174, 551, 90, 32, 428, 544, 96, 422, 170};

   initial begin
      model_reset();
      @(negedge clk);
      do_reset();
      // Mixed stream over several sets
      foreach (stream[i]) access(stream[i], "");
      // R1: offset bits do not change the line
      access(16'h0300, "");
      access(16'h030F, "R1");
      idle("R2");
      // R5/R6: four lines in set 0, then revisit evicted ones
      access(16'h1000, "");
      access(16'h1080, "");
      access(16'h1100, "");
      access(16'h1180, "R5");
      access(16'h1100, "R5");
      access(16'h1000, "R6");
      access(16'h1080, "R6");
      // R7: sweep 30 lines, then revisit the first
      for (int i = 0; i < 30; i++) access(16'h2000 + i * 16, "");
      access(16'h2000, "R7");
      access(16'h2010, "R7");
      idle("R2");
      // R8: reset forgets every line
      do_reset();
      access(16'h2000, "R8");
      // R9: overflow the first-touch table
      for (int i = 1; i < 66; i++) access(16'h4000 + i * 16, "");
      access(16'h2000, "R9");
      access(16'h7000, "R9");
      idle("R9");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule